// File: doc/BRIEF.md
# Int8 Tile Dot-Product Accumulator

This block is a sequential engine that multiplies two tiles of 8-bit integers and adds the product into a tile of 32-bit accumulators: C[M][N] += A[M][K] * B[K][N]. A start pulse carries the tile shape (M output rows, N dword columns, K bytes of reduction) and two mode bits. One mode bit marks the A operand as signed or unsigned and the other does the same for B, which gives the four mixes: signed by signed, signed by unsigned, unsigned by signed and unsigned by unsigned.

Tile storage sits outside the block. The engine fetches one A row, one B row and one C row at a time through row read ports, and it returns each updated C row through a row write port. Every B row packs four int8 values per dword column, so one reduction step consumes one dword of A (4 bytes) and one full B row. A bank of multiply-add lanes handles all dword columns of a row in parallel, one reduction step per cycle. For each output row the engine loads the old C row, runs every reduction step and then writes the row back. After the last row it raises done for one cycle.

Top module: `tdp_int8_acc`

## Requirements
- R1: While rst_ni is low, done_o and c_wr_en_o are 0.
- R2: For every row i < M and column j < N, the written C element equals the old C element plus the sum, over all reduction steps, of the four byte products, wrapped modulo 2^32 with no saturation.
- R3: Before it is multiplied, each A byte is sign-extended when a_signed_i=1 and zero-extended when a_signed_i=0. B bytes follow b_signed_i in the same way. The mode bits are sampled at start.
- R4: In reduction step s, byte b (0..3) of column j multiplies A row byte 4s+b (bits [8(4s+b)+:8] of a_row_i) by byte b of dword j (bits [32j+8b+:8]) of B row s. C column j occupies bits [32j+:32] of a C row.
- R5: k_i counts bytes. The number of reduction steps is floor(k_i/4), and only B rows 0 to steps-1 are read.
- R6: In each written row, columns j >= N carry the old C value unchanged. Rows i >= M are never written.
- R7: Rows 0 to M-1 are written exactly once each, in ascending order, and each row is written only after all of its reduction steps.
- R8: A start with M=0, N=0 or floor(K/4)=0 raises done_o in the next cycle and performs no write.
- R9: done_o is high for exactly one cycle, and that cycle is the one right after the last row write.
- R10: A start pulse that arrives while an operation is in progress is ignored. It changes neither the result nor the number of writes.
- R11: The read ports are combinational. Row data must be valid in the same cycle as the address that selects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled only while idle |
| m_i | input | 5 | Output row count M (0..16) |
| n_i | input | 5 | Dword column count N (0..16) |
| k_i | input | 7 | Reduction length K in bytes (0..64) |
| a_signed_i | input | 1 | 1: A bytes signed, 0: unsigned |
| b_signed_i | input | 1 | 1: B bytes signed, 0: unsigned |
| a_addr_o | output | 4 | A row index |
| a_row_i | input | 512 | A row data |
| b_addr_o | output | 4 | B row index (reduction step) |
| b_row_i | input | 512 | B row data |
| c_rd_addr_o | output | 4 | C row read index |
| c_rd_row_i | input | 512 | C row read data |
| c_wr_en_o | output | 1 | C row write strobe |
| c_wr_addr_o | output | 4 | C row write index |
| c_wr_row_o | output | 512 | Updated C row |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The main function is exercised with random tiles in all four signedness modes:
- Mixed signs separate sign extension from zero extension on each operand independently.
- A full 16x16x64 shape stresses every lane and every byte position.
- Partial shapes (N smaller than 16, K not a multiple of 4) expose columns that must stay untouched and the rounding of the step count.
- A constant pattern starts from accumulators just below 2^32 to show wrap-around rather than saturation.
- Zero shapes and a start pulse injected mid-run separate an idle engine from one that wrongly restarts or writes.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD_C,
    ST_MAC,
    ST_WRITE_C,
    ST_DONE
  } tdp_state_e;

  function automatic logic signed [8:0] ext9(input logic [7:0] v, input logic sgn);
    return $signed({sgn & v[7], v});
  endfunction
endpackage

// File: rtl/tdp_lane.sv
module tdp_lane
  import tdp_pkg::*;
(
  input  logic [31:0] a_dw_i,
  input  logic [31:0] b_dw_i,
  input  logic        a_sgn_i,
  input  logic        b_sgn_i,
  input  logic [31:0] acc_i,
  output logic [31:0] acc_o
);
  logic signed [19:0] dot;

  always_comb begin
    dot = '0;
    for (int i = 0; i < 4; i++) begin
      dot = dot + 20'(ext9(a_dw_i[8*i +: 8], a_sgn_i) * ext9(b_dw_i[8*i +: 8], b_sgn_i));
    end
  end

  // sign-extended dot added modulo 2^32
  assign acc_o = acc_i + 32'(dot);
endmodule

// File: rtl/tdp_ctrl.sv
module tdp_ctrl
  import tdp_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int KSTEPS = 16,
  parameter int MW     = 5,
  parameter int NW     = 5,
  parameter int KW     = 7,
  parameter int RAW    = 4,
  parameter int SAW    = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [MW-1:0]  m_i,
  input  logic [NW-1:0]  n_i,
  input  logic [KW-1:0]  k_i,
  output tdp_state_e     state_o,
  output logic [RAW-1:0] row_o,
  output logic [SAW-1:0] step_o,
  output logic [NW-1:0]  n_o
);
  localparam int SW = KW - 2;

  tdp_state_e     state_q;
  logic [RAW-1:0] row_q;
  logic [SAW-1:0] step_q;
  logic [MW-1:0]  m_q;
  logic [NW-1:0]  n_q;
  logic [SW-1:0]  steps_q;
  logic           zero_shape;
  logic           unused_k;

  assign unused_k   = ^k_i[1:0];
  assign zero_shape = (m_i == '0) || (n_i == '0) || (k_i[KW-1:2] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      step_q  <= '0;
      m_q     <= '0;
      n_q     <= '0;
      steps_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          m_q     <= m_i;
          n_q     <= n_i;
          steps_q <= k_i[KW-1:2];
          row_q   <= '0;
          step_q  <= '0;
          state_q <= zero_shape ? ST_DONE : ST_LOAD_C;
        end
        ST_LOAD_C: begin
          step_q  <= '0;
          state_q <= ST_MAC;
        end
        ST_MAC: begin
          if (SW'(step_q) == steps_q - SW'(1)) state_q <= ST_WRITE_C;
          else step_q <= step_q + SAW'(1);
        end
        ST_WRITE_C: begin
          if (MW'(row_q) == m_q - MW'(1)) state_q <= ST_DONE;
          else begin
            row_q   <= row_q + RAW'(1);
            state_q <= ST_LOAD_C;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign row_o   = row_q;
  assign step_o  = step_q;
  assign n_o     = n_q;

  // R5
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MAC) |-> (SW'(step_q) < steps_q));

  // R6
  row_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WRITE_C) |-> (MW'(row_q) < m_q));

  // R10
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && state_q != ST_DONE) |=> ($stable(m_q) && $stable(n_q) && $stable(steps_q)));

  // R7
  row_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WRITE_C && state_o != ST_DONE) |=> (row_q == $past(row_q) + RAW'(1)) || (state_q == ST_DONE));

  localparam int UNUSED_R = ROWS + KSTEPS;
endmodule

// File: rtl/tdp_int8_acc.sv
module tdp_int8_acc
  import tdp_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int COLS   = 16,
  parameter int KBYTES = 64,
  localparam int KSTEPS = KBYTES / 4,
  localparam int MW     = $clog2(ROWS + 1),
  localparam int NW     = $clog2(COLS + 1),
  localparam int KW     = $clog2(KBYTES + 1),
  localparam int RAW    = $clog2(ROWS),
  localparam int SAW    = $clog2(KSTEPS),
  localparam int AW     = KBYTES * 8,
  localparam int CW     = COLS * 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [MW-1:0]  m_i,
  input  logic [NW-1:0]  n_i,
  input  logic [KW-1:0]  k_i,
  input  logic           a_signed_i,
  input  logic           b_signed_i,
  output logic [RAW-1:0] a_addr_o,
  input  logic [AW-1:0]  a_row_i,
  output logic [SAW-1:0] b_addr_o,
  input  logic [CW-1:0]  b_row_i,
  output logic [RAW-1:0] c_rd_addr_o,
  input  logic [CW-1:0]  c_rd_row_i,
  output logic           c_wr_en_o,
  output logic [RAW-1:0] c_wr_addr_o,
  output logic [CW-1:0]  c_wr_row_o,
  output logic           done_o
);
  tdp_state_e     state;
  logic [RAW-1:0] row;
  logic [SAW-1:0] step;
  logic [NW-1:0]  n_act;
  logic           a_sgn_q, b_sgn_q;
  logic [31:0]    acc_q   [COLS];
  logic [31:0]    lane_out[COLS];
  logic [31:0]    a_dw;

  tdp_ctrl #(
    .ROWS(ROWS), .KSTEPS(KSTEPS), .MW(MW), .NW(NW), .KW(KW), .RAW(RAW), .SAW(SAW)
  ) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .m_i     (m_i),
    .n_i     (n_i),
    .k_i     (k_i),
    .state_o (state),
    .row_o   (row),
    .step_o  (step),
    .n_o     (n_act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_sgn_q <= 1'b0;
      b_sgn_q <= 1'b0;
    end else if (state == ST_IDLE && start_i) begin
      a_sgn_q <= a_signed_i;
      b_sgn_q <= b_signed_i;
    end
  end

  assign a_dw = a_row_i[32*step +: 32];

  for (genvar j = 0; j < COLS; j++) begin : g_lane
    tdp_lane u_lane (
      .a_dw_i  (a_dw),
      .b_dw_i  (b_row_i[32*j +: 32]),
      .a_sgn_i (a_sgn_q),
      .b_sgn_i (b_sgn_q),
      .acc_i   (acc_q[j]),
      .acc_o   (lane_out[j])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) acc_q[j] <= '0;
      else if (state == ST_LOAD_C) acc_q[j] <= c_rd_row_i[32*j +: 32];
      else if (state == ST_MAC && NW'(j) < n_act) acc_q[j] <= lane_out[j];
    end

    assign c_wr_row_o[32*j +: 32] = acc_q[j];
  end

  assign a_addr_o    = row;
  assign b_addr_o    = step;
  assign c_rd_addr_o = row;
  assign c_wr_addr_o = row;
  assign c_wr_en_o   = (state == ST_WRITE_C);
  assign done_o      = (state == ST_DONE);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  zero_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && start_i && (m_i == '0 || n_i == '0 || k_i[KW-1:2] == '0))
      |=> (done_o && !c_wr_en_o));

  // R9
  done_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(c_wr_en_o) || $past(state == ST_IDLE)));

  // R3
  uu_nonneg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_MAC && !a_sgn_q && !b_sgn_q) |-> ((lane_out[0] - acc_q[0]) <= 32'd260100));

  // R6
  col_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_MAC && n_act < NW'(COLS)) |=> $stable(acc_q[COLS-1]));
endmodule

// File: tb/tdp_int8_acc_tb.sv
module tdp_int8_acc_tb;
  localparam int ROWS = 16, COLS = 16, KBYTES = 64, KSTEPS = KBYTES / 4;
  localparam int AW = KBYTES * 8, CW = COLS * 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, start;
  logic [4:0]    m_in, n_in;
  logic [6:0]    k_in;
  logic          a_s, b_s;
  logic [3:0]    a_addr, b_addr, c_rd_addr, c_wr_addr;
  logic [AW-1:0] a_row;
  logic [CW-1:0] b_row, c_rd_row, c_wr_row;
  logic          c_wr_en, done;

  logic [AW-1:0] a_mem [ROWS];
  logic [CW-1:0] b_mem [KSTEPS];
  logic [CW-1:0] c_mem [ROWS];
  logic [CW-1:0] exp_c [ROWS];

  assign a_row    = a_mem[a_addr];
  assign b_row    = b_mem[b_addr];
  assign c_rd_row = c_mem[c_rd_addr];

  tdp_int8_acc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .m_i(m_in), .n_i(n_in), .k_i(k_in),
    .a_signed_i(a_s), .b_signed_i(b_s),
    .a_addr_o(a_addr), .a_row_i(a_row), .b_addr_o(b_addr), .b_row_i(b_row),
    .c_rd_addr_o(c_rd_addr), .c_rd_row_i(c_rd_row),
    .c_wr_en_o(c_wr_en), .c_wr_addr_o(c_wr_addr), .c_wr_row_o(c_wr_row), .done_o(done)
  );

  int checks = 0, errors = 0, cyc = 0;
  int wr_cnt, order_bad, exp_row, last_wr;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n && c_wr_en) begin
      if (int'(c_wr_addr) != exp_row) order_bad++;
      exp_row++;
      c_mem[c_wr_addr] = c_wr_row;
      wr_cnt++;
      last_wr = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_el(int i, int j, int steps, bit as, bit bs, logic [31:0] init);
    logic [31:0] acc = init;
    for (int s = 0; s < steps; s++) begin
      for (int b = 0; b < 4; b++) begin
        logic [7:0] av8 = a_mem[i][8*(4*s+b) +: 8];
        logic [7:0] bv8 = b_mem[s][32*j+8*b +: 8];
        int av = as ? int'($signed(av8)) : int'(av8);
        int bv = bs ? int'($signed(bv8)) : int'(bv8);
        acc = acc + 32'(av * bv);
      end
    end
    return acc;
  endfunction

  task automatic fill_rand();
    for (int i = 0; i < ROWS; i++)
      for (int w = 0; w < KBYTES / 4; w++) a_mem[i][32*w +: 32] = $urandom();
    for (int i = 0; i < KSTEPS; i++)
      for (int w = 0; w < COLS; w++) b_mem[i][32*w +: 32] = $urandom();
    for (int i = 0; i < ROWS; i++)
      for (int w = 0; w < COLS; w++) c_mem[i][32*w +: 32] = $urandom();
  endtask

  task automatic run_op(input int m, input int n, input int k, input bit as, input bit bs,
                        input bit poke, input string req);
    int steps = k / 4;
    bit zero = (m == 0) || (n == 0) || (steps == 0);
    bit seen = 0;
    int done_cyc = 0, start_cyc, bad_rows = 0, first_bad = -1;
    for (int i = 0; i < ROWS; i++) exp_c[i] = c_mem[i];
    if (!zero)
      for (int i = 0; i < m; i++)
        for (int j = 0; j < n; j++)
          exp_c[i][32*j +: 32] = ref_el(i, j, steps, as, bs, c_mem[i][32*j +: 32]);
    wr_cnt = 0; order_bad = 0; exp_row = 0;
    @(negedge clk);
    start = 1; m_in = 5'(m); n_in = 5'(n); k_in = 7'(k); a_s = as; b_s = bs;
    start_cyc = cyc;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (2) @(negedge clk);
      start = 1; m_in = 5'd1; n_in = 5'd1; k_in = 7'd4; a_s = ~as; b_s = ~bs;
      @(negedge clk);
      start = 0;
    end
    for (int t = 0; t < 3000 && !seen; t++) begin
      if (done) begin seen = 1; done_cyc = cyc; end
      else @(negedge clk);
    end
    chk(seen, "R9", "done seen", 64'(seen), 64'd1);
    @(negedge clk);
    chk(!done, "R9", "done width one cycle", 64'(done), 64'd0);
    if (poke) begin
      repeat (5) @(negedge clk);
      chk(!done, "R10", "no second done", 64'(done), 64'd0);
    end
    for (int i = 0; i < ROWS; i++)
      if (c_mem[i] !== exp_c[i]) begin
        bad_rows++;
        if (first_bad < 0) first_bad = i;
      end
    if (bad_rows != 0)
      chk(0, req, $sformatf("C row %0d low dword", first_bad),
          64'(c_mem[first_bad][31:0]), 64'(exp_c[first_bad][31:0]));
    else chk(1, req, "C tile", 0, 0);
    chk(wr_cnt == (zero ? 0 : m), zero ? "R8" : "R7", "write count", 64'(wr_cnt), 64'(zero ? 0 : m));
    chk(order_bad == 0, "R7", "row order errors", 64'(order_bad), 64'd0);
    if (zero) chk(done_cyc == start_cyc + 1, "R8", "zero-shape done cycle", 64'(done_cyc), 64'(start_cyc + 1));
    else chk(done_cyc == last_wr + 1, "R9", "done after last write", 64'(done_cyc), 64'(last_wr + 1));
  endtask

  task automatic t_reset();
    rst_n = 0; start = 0; m_in = 0; n_in = 0; k_in = 0; a_s = 0; b_s = 0;
    repeat (3) @(negedge clk);
    chk(!done && !c_wr_en, "R1", "outputs in reset", {62'd0, done, c_wr_en}, 64'd0);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < ROWS; i++) begin
      a_mem[i] = {AW{1'b1}} >> 0;
      for (int w = 0; w < KBYTES; w++) a_mem[i][8*w +: 8] = 8'h7f;
      for (int w = 0; w < COLS; w++) c_mem[i][32*w +: 32] = 32'hffff_fff0;
    end
    for (int s = 0; s < KSTEPS; s++)
      for (int w = 0; w < KBYTES; w++) b_mem[s][8*w +: 8] = 8'h7f;
    run_op(2, 16, 64, 0, 0, 0, "R2");
    chk(c_mem[0][31:0] == 32'(64'h0_ffff_fff0 + 64'd64 * 64'd16129), "R2", "wrap value",
        64'(c_mem[0][31:0]), 64'(32'(64'h0_ffff_fff0 + 64'd64 * 64'd16129)));
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    fill_rand(); run_op(4, 4, 16, 0, 0, 0, "R2");      // R2 R3 unsigned x unsigned
    fill_rand(); run_op(16, 16, 64, 1, 1, 0, "R4");    // R4 full shape, signed x signed
    fill_rand(); run_op(3, 5, 8, 1, 0, 0, "R6");       // R6 partial N, signed x unsigned
    fill_rand(); run_op(5, 16, 32, 0, 1, 0, "R3");     // R3 unsigned x signed
    fill_rand(); run_op(2, 3, 6, 1, 1, 0, "R5");       // R5 K floor to one step
    t_wrap();                                          // R2 modulo wrap
    fill_rand(); run_op(0, 4, 16, 1, 1, 0, "R8");      // R8 zero M
    run_op(4, 0, 16, 1, 1, 0, "R8");                   // R8 zero N
    run_op(4, 4, 3, 1, 1, 0, "R8");                    // R8 K below one step
    fill_rand(); run_op(6, 9, 40, 0, 1, 1, "R10");     // R10 start while busy
    fill_rand(); run_op(1, 16, 64, 1, 0, 0, "R11");    // R11 same-cycle reads, single row
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule